// File: doc/BRIEF.md
# Coprocessor Message Mailbox

This block moves fixed-size messages between an application processor and an I/O coprocessor. Two independent queues are held inside it: an outbound queue written by the application side and drained by the coprocessor, and an inbound queue written by the coprocessor and drained by the application side. A message is one 64-bit word plus one 32-bit word. Both processors reach the same register set through one 64-bit register bus. The bus uses a valid/ready request and returns read data one cycle after acceptance.

A sender first writes word 0 into the queue's staging window. It then writes word 1, and that second write pushes the whole message. A receiver may peek word 0 as often as it likes. The read of word 1 removes the entry, and that read also returns the queue's pointers and counters above the payload. Four status conditions are latched: each queue empty and each queue not empty. A latched bit stays set until software writes a 1 to it, and it latches again on the next cycle if its condition still holds. Two interrupt lines are formed from the latched bits under an enable mask.

The bus port is served by a two-state machine. In BUS_IDLE the block accepts one request per cycle. A write completes there and the machine stays in BUS_IDLE. An accepted read moves it to BUS_RESP, where it presents the read data for one cycle with bus_ready low, and it then always returns to BUS_IDLE.

Top module: `coproc_mailbox`

## Requirements
- R1: After reset both queue control words read 0x20000 (bit 17 empty set, bit 16 full clear, bit 0 overflow clear), the enable word reads 0, and both interrupt lines are low.
- R2: In BUS_IDLE bus_ready is high. A read accepted on a clock edge is answered in the following cycle with bus_rvalid high and bus_ready low, and the machine then returns to BUS_IDLE. A write needs one accepted cycle.
- R3: A write to a queue's send-0 window (outbound 0x60, inbound 0x90) only stages word 0. A write to its send-1 window (outbound 0x68, inbound 0x98) pushes the staged word 0 together with bits 31:0 of the write. Bits 63:32 of that write are ignored.
- R4: Messages leave each queue in the order they were pushed. A read of recv-0 (outbound 0x70, inbound 0xA0) returns the head word 0 and leaves the queue unchanged. A read of recv-1 (outbound 0x78, inbound 0xA8) removes the head entry.
- R5: Each queue holds 8 messages. When it is full, control bit 16 reads 1. A send-1 write while full is dropped and sets control bit 0. Writing a 1 to bit 0 of the control word (outbound 0x50, inbound 0x80) clears it.
- R6: A recv-0 or recv-1 read of an empty queue returns all zeros and changes no pointer or counter.
- R7: A recv-1 read returns its values as they stood before the removal: the payload in bits 31:0, the 4-bit write pointer in 43:40, the 4-bit read pointer in 47:44, the number of held entries in 51:48, and the number of removals so far (mod 32) in 56:52. All other bits are 0.
- R8: The latched status word reads at 0x4C with bit 0 outbound empty, bit 1 outbound not empty, bit 2 inbound empty and bit 3 inbound not empty. A bit sets whenever its condition holds and stays set after the condition goes away.
- R9: Writing 1s to 0x4C clears those latched bits. A read accepted on the very next cycle sees them clear. A bit whose condition still holds is set again from the cycle after that.
- R10: The enable word at 0x48 (bits 3:0, same positions as 0x4C) reads back as written. irq_app is the OR of latched-and-enabled bits 0 and 3. irq_iop is the OR of latched-and-enabled bits 1 and 2.
- R11: Traffic on one queue leaves the other queue's control word, pointers and counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request accepted this cycle when high with bus_valid |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 64 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read is accepted |
| bus_rdata | output | 64 | Read data |
| irq_app | output | 1 | Interrupt toward the application side (outbound empty, inbound not empty) |
| irq_iop | output | 1 | Interrupt toward the coprocessor side (outbound not empty, inbound empty) |

## Verification
The hardest case to reach from the ports is the one-cycle gap after an acknowledge while the condition still holds. It can only be seen by a read that the bus accepts on the cycle directly after the acknowledge write. The stimulus therefore issues that read back-to-back with the write, and then issues a second read to see the bit return. The dropped push at full needs eight accepted pushes first. After it, the bench drains the queue to confirm that neither the order nor the write pointer moved.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // register addresses (byte addresses on the 8-bit bus)
    localparam logic [7:0] ADR_IRQ_EN   = 8'h48;
    localparam logic [7:0] ADR_IRQ_ACK  = 8'h4C;
    localparam logic [7:0] ADR_OUT_BASE = 8'h50;
    localparam logic [7:0] ADR_IN_BASE  = 8'h80;

    // offsets from a queue's control word
    localparam logic [7:0] OFS_SEND0 = 8'h10;
    localparam logic [7:0] OFS_SEND1 = 8'h18;
    localparam logic [7:0] OFS_RECV0 = 8'h20;
    localparam logic [7:0] OFS_RECV1 = 8'h28;

    localparam int NSRC   = 4;
    localparam int FLD_W  = 4;
    localparam int POPC_W = 5;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_t;

    function automatic logic [63:0] ctl_word(input logic is_empty,
                                             input logic is_full,
                                             input logic ovf);
        return {46'd0, is_empty, is_full, 15'd0, ovf};
    endfunction

    function automatic logic [63:0] recv1_word(input logic [31:0]       payload,
                                               input logic [FLD_W-1:0]  wptr,
                                               input logic [FLD_W-1:0]  rptr,
                                               input logic [FLD_W-1:0]  held,
                                               input logic [POPC_W-1:0] pops);
        return {7'd0, pops, held, rptr, wptr, 8'd0, payload};
    endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int DEPTH_LOG2 = 3,
    parameter int W0_W       = 64,
    parameter int W1_W       = 32,
    parameter int POPC_W     = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stage_we,
    input  logic [W0_W-1:0]       stage_data,
    input  logic                  push,
    input  logic [W1_W-1:0]       push_w1,
    input  logic                  pop,
    input  logic                  ovf_clr,
    output logic [W0_W-1:0]       head_w0,
    output logic [W1_W-1:0]       head_w1,
    output logic                  full,
    output logic                  empty,
    output logic                  ovf,
    output logic [DEPTH_LOG2:0]   wr_ptr,
    output logic [DEPTH_LOG2:0]   rd_ptr,
    output logic [DEPTH_LOG2:0]   level,
    output logic [POPC_W-1:0]     pop_cnt
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam int PW    = DEPTH_LOG2 + 1;

    logic [W0_W-1:0]       stg_q;
    logic [W0_W-1:0]       mem0 [DEPTH];
    logic [W1_W-1:0]       mem1 [DEPTH];
    logic [PW-1:0]         wr_q, rd_q;
    logic                  ovf_q;
    logic [POPC_W-1:0]     popc_q;
    logic                  do_push, do_pop;

    assign level   = wr_q - rd_q;
    assign empty   = (wr_q == rd_q);
    assign full    = (level == PW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q  <= '0;
            wr_q   <= '0;
            rd_q   <= '0;
            ovf_q  <= 1'b0;
            popc_q <= '0;
        end else begin
            if (stage_we) stg_q <= stage_data;
            if (do_push)  wr_q  <= wr_q + 1'b1;
            if (do_pop) begin
                rd_q   <= rd_q + 1'b1;
                popc_q <= popc_q + 1'b1;
            end
            if (push && full) ovf_q <= 1'b1;
            else if (ovf_clr) ovf_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem0[wr_q[DEPTH_LOG2-1:0]] <= stg_q;
            mem1[wr_q[DEPTH_LOG2-1:0]] <= push_w1;
        end
    end

    assign head_w0 = mem0[rd_q[DEPTH_LOG2-1:0]];
    assign head_w1 = mem1[rd_q[DEPTH_LOG2-1:0]];
    assign ovf     = ovf_q;
    assign wr_ptr  = wr_q;
    assign rd_ptr  = rd_q;
    assign pop_cnt = popc_q;

    // R5: a push into a full queue leaves the write pointer alone
    assert_drop_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> $stable(wr_q));
    // R5: that dropped push raises the overflow flag
    assert_ovf_on_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> ovf_q);
    // R5: occupancy never exceeds the depth
    assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        level <= PW'(DEPTH));
    // R6: a removal from an empty queue moves nothing
    assert_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> ($stable(rd_q) && $stable(popc_q)));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
    parameter int               NSRC   = 4,
    parameter logic [NSRC-1:0]  MASK_A = 4'b1001,
    parameter logic [NSRC-1:0]  MASK_B = 4'b0110
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] cond,
    input  logic [NSRC-1:0] ack,
    input  logic [NSRC-1:0] en,
    output logic [NSRC-1:0] lat,
    output logic            line_a,
    output logic            line_b
);
    logic [NSRC-1:0] lat_q;

    // an acknowledged bit is held clear for one cycle, then may latch again
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= (lat_q | cond) & ~ack;
    end

    assign lat    = lat_q;
    assign line_a = |(lat_q & en & MASK_A);
    assign line_b = |(lat_q & en & MASK_B);

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        // R9: acknowledge clears the bit on the next cycle
        assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ack[i] |=> !lat_q[i]);
        // R8: an unacknowledged bit is sticky
        assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (lat_q[i] && !ack[i]) |=> lat_q[i]);
        // R8: a true condition latches
        assert_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cond[i] && !ack[i]) |=> lat_q[i]);
    end
endmodule

// File: rtl/coproc_mailbox.sv
module coproc_mailbox #(
    parameter int DEPTH_LOG2 = 3,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 64,
    parameter int MSG1_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    output logic              bus_ready,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_app,
    output logic              irq_iop
);
    import mbx_pkg::*;

    localparam int NQ = 2;
    localparam int PW = DEPTH_LOG2 + 1;
    localparam logic [7:0] QBASE [NQ] = '{ADR_OUT_BASE, ADR_IN_BASE};

    // ---------------- bus state machine ----------------
    bus_state_t state_q, state_d;
    logic acc, wr_acc, rd_acc;

    assign acc    = bus_valid && bus_ready;
    assign wr_acc = acc && bus_write;
    assign rd_acc = acc && !bus_write;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_acc) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        bus_ready  = 1'b0;
        bus_rvalid = 1'b0;
        unique case (state_q)
            BUS_IDLE: bus_ready  = 1'b1;
            BUS_RESP: bus_rvalid = 1'b1;
        endcase
    end

    // ---------------- queues ----------------
    logic [NQ-1:0]         q_stage, q_push, q_pop, q_oclr;
    logic [NQ-1:0]         q_full, q_empty, q_ovf;
    logic [DATA_W-1:0]     q_h0   [NQ];
    logic [MSG1_W-1:0]     q_h1   [NQ];
    logic [PW-1:0]         q_wp   [NQ];
    logic [PW-1:0]         q_rp   [NQ];
    logic [PW-1:0]         q_lvl  [NQ];
    logic [POPC_W-1:0]     q_pc   [NQ];

    for (genvar g = 0; g < NQ; g++) begin : g_q
        assign q_stage[g] = wr_acc && (bus_addr == ADDR_W'(QBASE[g] + OFS_SEND0));
        assign q_push[g]  = wr_acc && (bus_addr == ADDR_W'(QBASE[g] + OFS_SEND1));
        assign q_oclr[g]  = wr_acc && (bus_addr == ADDR_W'(QBASE[g])) && bus_wdata[0];
        assign q_pop[g]   = rd_acc && (bus_addr == ADDR_W'(QBASE[g] + OFS_RECV1));

        mbx_fifo #(
            .DEPTH_LOG2 (DEPTH_LOG2),
            .W0_W       (DATA_W),
            .W1_W       (MSG1_W),
            .POPC_W     (POPC_W)
        ) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .stage_we   (q_stage[g]),
            .stage_data (bus_wdata),
            .push       (q_push[g]),
            .push_w1    (bus_wdata[MSG1_W-1:0]),
            .pop        (q_pop[g]),
            .ovf_clr    (q_oclr[g]),
            .head_w0    (q_h0[g]),
            .head_w1    (q_h1[g]),
            .full       (q_full[g]),
            .empty      (q_empty[g]),
            .ovf        (q_ovf[g]),
            .wr_ptr     (q_wp[g]),
            .rd_ptr     (q_rp[g]),
            .level      (q_lvl[g]),
            .pop_cnt    (q_pc[g])
        );
    end

    // ---------------- interrupt status ----------------
    logic [NSRC-1:0] en_q, irq_ack, irq_cond, irq_lat;

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else if (wr_acc && bus_addr == ADDR_W'(ADR_IRQ_EN)) en_q <= bus_wdata[NSRC-1:0];
    end

    assign irq_ack  = (wr_acc && bus_addr == ADDR_W'(ADR_IRQ_ACK)) ? bus_wdata[NSRC-1:0] : '0;
    assign irq_cond = {~q_empty[1], q_empty[1], ~q_empty[0], q_empty[0]};

    mbx_irq #(
        .NSRC   (NSRC),
        .MASK_A (4'b1001),
        .MASK_B (4'b0110)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond   (irq_cond),
        .ack    (irq_ack),
        .en     (en_q),
        .lat    (irq_lat),
        .line_a (irq_app),
        .line_b (irq_iop)
    );

    // ---------------- read data ----------------
    logic [DATA_W-1:0] rd_mux, rdata_q;

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(ADR_IRQ_EN))  rd_mux = DATA_W'(en_q);
        if (bus_addr == ADDR_W'(ADR_IRQ_ACK)) rd_mux = DATA_W'(irq_lat);
        for (int g = 0; g < NQ; g++) begin
            if (bus_addr == ADDR_W'(QBASE[g]))
                rd_mux = ctl_word(q_empty[g], q_full[g], q_ovf[g]);
            if (bus_addr == ADDR_W'(QBASE[g] + OFS_RECV0) && !q_empty[g])
                rd_mux = q_h0[g];
            if (bus_addr == ADDR_W'(QBASE[g] + OFS_RECV1) && !q_empty[g])
                rd_mux = recv1_word(q_h1[g], FLD_W'(q_wp[g]), FLD_W'(q_rp[g]),
                                    FLD_W'(q_lvl[g]), q_pc[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_acc) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    // R2: every accepted read is answered on the next cycle
    assert_read_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> bus_rvalid);
    // R2: a response lasts one cycle
    assert_resp_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> !bus_rvalid);
    // R2: no request accepted while answering
    assert_no_accept_in_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> !bus_ready);
    // R11: traffic on the outbound queue leaves the inbound pointers alone
    assert_queue_isolation_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((q_push[0] || q_pop[0]) && !q_push[1] && !q_pop[1]) |=> ($stable(q_wp[1]) && $stable(q_rp[1])));
endmodule

// File: tb/coproc_mailbox_bench.sv
module coproc_mailbox_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        bus_ready, bus_rvalid, irq_app, irq_iop;
    logic [63:0] bus_rdata;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;   // 50 MHz

    coproc_mailbox u_coproc_mailbox (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_ready  (bus_ready),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rvalid (bus_rvalid),
        .bus_rdata  (bus_rdata),
        .irq_app    (irq_app),
        .irq_iop    (irq_iop)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // tasks are entered at a falling edge
    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        while (!bus_ready) @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        while (!bus_ready) @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
        chk("R2", {62'd0, bus_rvalid, bus_ready}, 64'd2);  // R2 response handshake
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // vector: {req, write, addr, data/expected}
    localparam int NVEC = 20;
    localparam logic [76:0] VEC [NVEC] = '{
        {4'd1,  1'b0, 8'h50, 64'h0000_0000_0002_0000},   // R1 outbound empty
        {4'd1,  1'b0, 8'h80, 64'h0000_0000_0002_0000},   // R1 inbound empty
        {4'd1,  1'b0, 8'h48, 64'h0},                     // R1 enables clear
        {4'd3,  1'b1, 8'h60, 64'h1111_2222_3333_4444},   // R3 stage
        {4'd3,  1'b0, 8'h50, 64'h0000_0000_0002_0000},   // R3 staging alone pushes nothing
        {4'd3,  1'b1, 8'h68, 64'hDEAD_0000_AAAA_0001},   // R3 push, high half ignored
        {4'd3,  1'b0, 8'h50, 64'h0},
        {4'd3,  1'b0, 8'h70, 64'h1111_2222_3333_4444},
        {4'd4,  1'b0, 8'h70, 64'h1111_2222_3333_4444},   // R4 peek again
        {4'd7,  1'b0, 8'h78, 64'h0001_0100_AAAA_0001},   // R7 fields
        {4'd4,  1'b0, 8'h50, 64'h0000_0000_0002_0000},   // R4 removed
        {4'd6,  1'b0, 8'h78, 64'h0},                     // R6
        {4'd6,  1'b0, 8'h70, 64'h0},                     // R6
        {4'd3,  1'b1, 8'h90, 64'h0000_0000_0000_5555},
        {4'd3,  1'b1, 8'h98, 64'h0000_0000_0000_0077},
        {4'd11, 1'b0, 8'h50, 64'h0000_0000_0002_0000},   // R11 outbound unaffected
        {4'd3,  1'b0, 8'hA0, 64'h0000_0000_0000_5555},
        {4'd7,  1'b0, 8'hA8, 64'h0001_0100_0000_0077},   // R7 inbound
        {4'd6,  1'b0, 8'hA8, 64'h0},                     // R6 after drain
        {4'd11, 1'b0, 8'h80, 64'h0000_0000_0002_0000}    // R11
    };

    initial begin
        repeat (1000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] d;
        idle(3);
        rst_n = 1'b1;
        chk("R1", {62'd0, irq_app, irq_iop}, 64'd0);
        chk("R2", {63'd0, bus_ready}, 64'd1);
        idle(2);

        for (int i = 0; i < NVEC; i++) begin
            logic [76:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d", v[76:73]);
            if (v[72]) wr(v[71:64], v[63:0]);
            else begin
                rd(v[71:64], d);
                chk(tag, d, v[63:0]);
            end
        end

        // R5 / R4 / R7: fill, overflow, drain in order
        for (int i = 0; i < 8; i++) begin
            wr(8'h60, 64'hA000 + 64'(i));
            wr(8'h68, 64'hB000 + 64'(i));
        end
        rd(8'h50, d); chk("R5", d, 64'h1_0000);
        wr(8'h60, 64'hFFFF); wr(8'h68, 64'hFFFF);
        rd(8'h50, d); chk("R5", d, 64'h1_0001);
        wr(8'h50, 64'h1);
        rd(8'h50, d); chk("R5", d, 64'h1_0000);
        for (int i = 0; i < 8; i++) begin
            logic [63:0] e;
            rd(8'h70, d); chk("R4", d, 64'hA000 + 64'(i));
            e = (64'(1 + i) << 52) | (64'(8 - i) << 48) | (64'(1 + i) << 44)
                | (64'd9 << 40) | (64'hB000 + 64'(i));
            rd(8'h78, d); chk("R7", d, e);
        end
        rd(8'h50, d); chk("R4", d, 64'h2_0000);

        // R8 / R9 / R10: latched status
        rd(8'h4C, d); chk("R8", d, 64'hF);
        wr(8'h4C, 64'hF);
        rd(8'h4C, d); chk("R9", d, 64'h0);
        rd(8'h4C, d); chk("R9", d, 64'h5);
        chk("R10", {62'd0, irq_app, irq_iop}, 64'd0);
        wr(8'h48, 64'h1);
        idle(1);
        chk("R10", {62'd0, irq_app, irq_iop}, 64'd2);
        rd(8'h48, d); chk("R10", d, 64'h1);
        wr(8'h48, 64'h2);
        idle(1);
        chk("R10", {62'd0, irq_app, irq_iop}, 64'd0);
        wr(8'h60, 64'h1); wr(8'h68, 64'h2);
        idle(2);
        chk("R10", {62'd0, irq_app, irq_iop}, 64'd1);
        wr(8'h4C, 64'h1);
        idle(2);
        rd(8'h4C, d); chk("R9", d, 64'h6);
        rd(8'h78, d);
        idle(2);
        rd(8'h4C, d); chk("R8", d, 64'h7);
        chk("R8", {62'd0, irq_app, irq_iop}, 64'd1);
        wr(8'h4C, 64'h2);
        idle(1);
        chk("R9", {62'd0, irq_app, irq_iop}, 64'd0);

        // R1: reset mid-run
        wr(8'h48, 64'hF);
        wr(8'h90, 64'h3); wr(8'h98, 64'h4);
        idle(2);
        rst_n = 1'b0;
        idle(2);
        chk("R1", {62'd0, irq_app, irq_iop}, 64'd0);
        rst_n = 1'b1;
        rd(8'h80, d); chk("R1", d, 64'h2_0000);
        rd(8'h48, d); chk("R1", d, 64'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule